// File: doc/BRIEF.md
# Unaligned Word Load-Store Merger

This block carries out the four partial-word memory operations of a little-endian 32-bit core: filling the high-order or low-order part of a register from a word that straddles an alignment boundary, and spilling the high-order or low-order part of a register into memory. A request carries the operation, the effective byte address, the current register value and the destination register index. The block reads the aligned memory word, merges bytes with a shift and a mask chosen by the low address bits, and either returns the merged register value or writes the merged word back to memory.

Requests arrive on a valid/ready stream. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Results leave on a second valid/ready stream. Once `res_valid` rises, the result fields stay constant until a clock edge with `res_ready` high. Only one request is in flight at a time. A sender that holds `req_valid` high simply waits, and a receiver that holds `res_ready` low stalls the block without losing anything. The memory side is plain control: a one-cycle read strobe, with the data returned on `mem_rd_data` in the cycle after the strobe, and a one-cycle write strobe.

Top module: `pw_merger`

## Requirements
- R1: While reset is held and directly after it, `req_ready` is 1 and `res_valid`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: In the cycle after a request is accepted, `mem_rd_en` is 1 and `mem_addr` equals the request address with bits 1:0 cleared. Those two bits form the byte offset `off`.
- R3: Operation code 2'b00 (fill high) returns `(mem << {24,16,8,0}[off]) | (reg & {0x00FFFFFF,0x0000FFFF,0x000000FF,0}[off])`.
- R4: Operation code 2'b01 (fill low) returns `(mem >> {0,8,16,24}[off]) | (reg & {0,0xFF000000,0xFFFF0000,0xFFFFFF00}[off])`.
- R5: Operation code 2'b10 (spill high) writes `(reg >> {24,16,8,0}[off]) | (mem & {0xFFFFFF00,0xFFFF0000,0xFF000000,0}[off])`. The write strobe comes in the cycle right after the read strobe and uses the same aligned address.
- R6: Operation code 2'b11 (spill low) writes `(reg << {0,8,16,24}[off]) | (mem & {0,0xFF,0xFFFF,0xFFFFFF}[off])`.
- R7: Every request causes exactly one read. A fill causes no write, and a spill causes exactly one write. A read and a write never occur in the same cycle.
- R8: `res_wr` is 1 only for a fill whose destination index is non-zero. A fill into index 0 still performs its memory read. For a spill, `res_data` carries the written word and `res_wr` is 0.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data`, `res_dest` and `res_wr` hold their values. `req_ready` stays 0 from acceptance until the result has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | Operation: bit 1 = spill, bit 0 = low side |
| req_addr | input | ADDR_W | Effective byte address |
| req_reg | input | DATA_W | Register value (old destination value or store source) |
| req_dest | input | IDX_W | Destination register index |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Aligned word address |
| mem_wr_data | output | DATA_W | Merged word to write |
| mem_rd_data | input | DATA_W | Read word, valid the cycle after the strobe |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Receiver takes the result |
| res_data | output | DATA_W | Merged register value or written word |
| res_dest | output | IDX_W | Destination index of the result |
| res_wr | output | 1 | Register file must be written |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 32-bit address and a 5-bit register index. With these values all four byte offsets are reachable and the shift and mask constants are the ones given in R3 to R6. The memory model covers only sixteen words, so spills and later fills often hit the same word. That exercises read-modify-write through the real memory contents. Runs both with and without result back-pressure show that results are held and that requests are refused while the block is busy.

// File: rtl/pw_merge_pkg.sv
package pw_merge_pkg;

  typedef enum logic [1:0] {
    OP_FILL_HI  = 2'b00,
    OP_FILL_LO  = 2'b01,
    OP_SPILL_HI = 2'b10,
    OP_SPILL_LO = 2'b11
  } pw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_READ  = 2'b01,
    ST_MERGE = 2'b10,
    ST_RESP  = 2'b11
  } pw_state_e;

  function automatic logic op_is_spill(input pw_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_low(input pw_op_e op);
    return op[0];
  endfunction

endpackage

// File: rtl/pw_load_merge.sv
module pw_load_merge #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              low_side,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] merged
);

  localparam int SH_W = OFF_W + 3;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic [SH_W-1:0]   sh_hi;
  logic [SH_W-1:0]   sh_lo;
  logic [DATA_W-1:0] keep_hi;
  logic [DATA_W-1:0] keep_lo;
  logic [DATA_W-1:0] part_hi;
  logic [DATA_W-1:0] part_lo;

  // High fill moves memory up by (NB-1-off) bytes; since NB is a power
  // of two that count is simply the bitwise complement of the offset.
  assign sh_hi = {~off, 3'b000};
  assign sh_lo = {off, 3'b000};

  assign keep_hi = ~(ONES << sh_hi);
  assign keep_lo = ~(ONES >> sh_lo);

  assign part_hi = (mem_word << sh_hi) | (reg_val & keep_hi);
  assign part_lo = (mem_word >> sh_lo) | (reg_val & keep_lo);

  generate
    if (NB == 1) begin : g_single
      assign merged = mem_word;
    end else begin : g_multi
      assign merged = low_side ? part_lo : part_hi;
    end
  endgenerate

endmodule

// File: rtl/pw_store_merge.sv
module pw_store_merge #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              low_side,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] merged
);

  localparam int SH_W = OFF_W + 3;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic [SH_W-1:0]   sh_hi;
  logic [SH_W-1:0]   sh_lo;
  logic [DATA_W-1:0] new_hi;
  logic [DATA_W-1:0] new_lo;
  logic [DATA_W-1:0] part_hi;
  logic [DATA_W-1:0] part_lo;

  assign sh_hi = {~off, 3'b000};
  assign sh_lo = {off, 3'b000};

  // Byte lanes taken from the register; the rest keep the memory word.
  assign new_hi = ONES >> sh_hi;
  assign new_lo = ONES << sh_lo;

  assign part_hi = (reg_val >> sh_hi) | (mem_word & ~new_hi);
  assign part_lo = (reg_val << sh_lo) | (mem_word & ~new_lo);

  generate
    if (NB == 1) begin : g_single
      assign merged = reg_val;
    end else begin : g_multi
      assign merged = low_side ? part_lo : part_hi;
    end
  endgenerate

endmodule

// File: rtl/pw_seq.sv
module pw_seq
  import pw_merge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  pw_op_e            req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [IDX_W-1:0]  req_dest,
  output pw_op_e            op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] reg_q,
  input  logic [DATA_W-1:0] merged_in,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_dest,
  output logic              res_wr
);

  pw_state_e           state_q;
  pw_state_e           state_d;
  logic [IDX_W-1:0]    dest_q;
  logic [DATA_W-1:0]   res_q;
  logic                accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_READ;
      ST_READ:  state_d = ST_MERGE;
      ST_MERGE: state_d = ST_RESP;
      ST_RESP:  if (res_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_FILL_HI;
      addr_q  <= '0;
      reg_q   <= '0;
      dest_q  <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= req_op;
        addr_q <= req_addr;
        reg_q  <= req_reg;
        dest_q <= req_dest;
      end
      if (state_q == ST_MERGE) begin
        res_q <= merged_in;
      end
    end
  end

  assign mem_rd_en = (state_q == ST_READ);
  assign mem_wr_en = (state_q == ST_MERGE) && op_is_spill(op_q);
  assign res_valid = (state_q == ST_RESP);
  assign res_data  = res_q;
  assign res_dest  = dest_q;
  assign res_wr    = !op_is_spill(op_q) && (dest_q != '0);

  AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_rd_en); // R2

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en)); // R5

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) &&
                                $stable(res_dest) && $stable(res_wr)); // R9

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en || res_valid) |-> !req_ready); // R9

endmodule

// File: rtl/pw_merger.sv
module pw_merger
  import pw_merge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [IDX_W-1:0]  req_dest,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_dest,
  output logic              res_wr
);

  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  pw_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] reg_q;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] fill_word;
  logic [DATA_W-1:0] spill_word;
  logic [DATA_W-1:0] merged;

  assign off      = addr_q[OFF_W-1:0];
  assign mem_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  pw_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (pw_op_e'(req_op)),
    .req_addr  (req_addr),
    .req_reg   (req_reg),
    .req_dest  (req_dest),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .reg_q     (reg_q),
    .merged_in (merged),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_dest  (res_dest),
    .res_wr    (res_wr)
  );

  pw_load_merge #(.DATA_W(DATA_W)) u_fill (
    .low_side (op_is_low(op_q)),
    .off      (off),
    .reg_val  (reg_q),
    .mem_word (mem_rd_data),
    .merged   (fill_word)
  );

  pw_store_merge #(.DATA_W(DATA_W)) u_spill (
    .low_side (op_is_low(op_q)),
    .off      (off),
    .reg_val  (reg_q),
    .mem_word (mem_rd_data),
    .merged   (spill_word)
  );

  assign merged      = op_is_spill(op_q) ? spill_word : fill_word;
  assign mem_wr_data = spill_word;

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> mem_addr[OFF_W-1:0] == '0); // R2

  AST_ZERO_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_wr |-> res_dest != '0); // R8

  AST_WRITE_DATA_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> res_valid && res_data == $past(mem_wr_data)); // R8

endmodule

// File: tb/tb_pw_merger.sv
`timescale 1ns/100ps
module tb_pw_merger;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  typedef struct {
    logic [31:0] data;
    logic [4:0]  dest;
    logic        wr;
    logic [1:0]  op;
  } res_item_t;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_reg = '0;
  logic [4:0]  req_dest = '0;
  logic mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wr_data;
  logic [31:0] mem_rd_data = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [31:0] res_data;
  logic [4:0]  res_dest;
  logic res_wr;

  int checks = 0;
  int errors = 0;
  int n_req = 0, n_spill = 0, n_rd = 0, n_wr = 0;
  bit bp_mode = 0;
  int bp_cnt = 0;
  bit done = 0;

  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  res_item_t res_q[$];
  logic [31:0] rda_q[$];
  wr_item_t wr_q[$];

  always #2.5 clk = ~clk;

  pw_merger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg), .req_dest(req_dest),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_dest(res_dest), .res_wr(res_wr)
  );

  // Memory with one cycle of read latency.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_addr[5:2]];
    if (mem_wr_en) mem[mem_addr[5:2]] <= mem_wr_data;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Reference model written straight from the requirement tables.
  function automatic logic [31:0] model(input logic [1:0] op, input logic [1:0] off,
                                        input logic [31:0] rv, input logic [31:0] mv);
    logic [31:0] r;
    case (op)
      2'b00: case (off) // R3
        2'd0: r = (mv << 24) | (rv & 32'h00FFFFFF);
        2'd1: r = (mv << 16) | (rv & 32'h0000FFFF);
        2'd2: r = (mv << 8)  | (rv & 32'h000000FF);
        default: r = mv;
      endcase
      2'b01: case (off) // R4
        2'd0: r = mv;
        2'd1: r = (mv >> 8)  | (rv & 32'hFF000000);
        2'd2: r = (mv >> 16) | (rv & 32'hFFFF0000);
        default: r = (mv >> 24) | (rv & 32'hFFFFFF00);
      endcase
      2'b10: case (off) // R5
        2'd0: r = (rv >> 24) | (mv & 32'hFFFFFF00);
        2'd1: r = (rv >> 16) | (mv & 32'hFFFF0000);
        2'd2: r = (rv >> 8)  | (mv & 32'hFF000000);
        default: r = rv;
      endcase
      default: case (off) // R6
        2'd0: r = rv;
        2'd1: r = (rv << 8)  | (mv & 32'h000000FF);
        2'd2: r = (rv << 16) | (mv & 32'h0000FFFF);
        default: r = (rv << 24) | (mv & 32'h00FFFFFF);
      endcase
    endcase
    return r;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] rv, input logic [4:0] dest);
    res_item_t it;
    wr_item_t w;
    logic [31:0] e;
    e = model(op, addr[1:0], rv, shadow[addr[5:2]]);
    if (op[1]) begin
      shadow[addr[5:2]] = e;
      w.addr = {addr[31:2], 2'b00};
      w.data = e;
      wr_q.push_back(w);
      n_spill++;
    end
    rda_q.push_back({addr[31:2], 2'b00});
    it.data = e;
    it.dest = dest;
    it.wr = !op[1] && (dest != 0);
    it.op = op;
    res_q.push_back(it);
    n_req++;
    @(negedge clk);
    req_valid = 1'b1;
    req_op = op;
    req_addr = addr;
    req_reg = rv;
    req_dest = dest;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: back-pressure generation, result scoreboard, memory strobes.
  logic stall_seen = 1'b0;
  logic [31:0] stall_data;
  logic [4:0]  stall_dest;
  logic        stall_wr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_seen) begin
        chk(res_valid && res_data == stall_data && res_dest == stall_dest &&
            res_wr == stall_wr, "R9 result held under stall", res_data, stall_data);
        chk(!req_ready, "R9 busy while result pending", {31'b0, req_ready}, 32'h0);
      end
      bp_cnt++;
      res_ready = bp_mode ? (bp_cnt % 3 == 0) : 1'b1;
      stall_seen = res_valid && !res_ready;
      stall_data = res_data;
      stall_dest = res_dest;
      stall_wr = res_wr;
      if (res_valid && res_ready) begin
        if (res_q.size() == 0) begin
          chk(0, "R7 unexpected result", res_data, 32'h0);
        end else begin
          res_item_t it;
          it = res_q.pop_front();
          case (it.op)
            2'b00: chk(res_data == it.data, "R3 fill-high data", res_data, it.data);
            2'b01: chk(res_data == it.data, "R4 fill-low data", res_data, it.data);
            2'b10: chk(res_data == it.data, "R5 spill-high returned word", res_data, it.data);
            default: chk(res_data == it.data, "R6 spill-low returned word", res_data, it.data);
          endcase
          chk(res_wr == it.wr && res_dest == it.dest, "R8 write flag and dest",
              {26'b0, res_dest, res_wr}, {26'b0, it.dest, it.wr});
        end
      end
      if (mem_rd_en) begin
        n_rd++;
        chk(!mem_wr_en, "R7 read and write together", 32'h1, 32'h0);
        if (rda_q.size() == 0) chk(0, "R2 unexpected read", mem_addr, 32'h0);
        else begin
          logic [31:0] ea;
          ea = rda_q.pop_front();
          chk(mem_addr == ea, "R2 aligned read address", mem_addr, ea);
        end
      end
      if (mem_wr_en) begin
        n_wr++;
        if (wr_q.size() == 0) chk(0, "R7 write from a fill", mem_addr, 32'h0);
        else begin
          wr_item_t w;
          w = wr_q.pop_front();
          chk(mem_addr == w.addr, "R5 write address", mem_addr, w.addr);
          chk(mem_wr_data == w.data, "R6 written word", mem_wr_data, w.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h11223344 ^ (i * 32'h01030507);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !mem_rd_en && !mem_wr_en, "R1 state in reset",
        {28'b0, req_ready, res_valid, mem_rd_en, mem_wr_en}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !res_valid && !mem_rd_en && !mem_wr_en, "R1 state after reset",
        {28'b0, req_ready, res_valid, mem_rd_en, mem_wr_en}, 32'h8);

    // Every operation at every offset.
    for (int op = 0; op < 4; op++)
      for (int off = 0; off < 4; off++)
        issue(op[1:0], 32'h0000_0010 + off[31:0], 32'hA1B2C3D4 + op * 32'h111, 5'd3 + off[4:0]);

    // Fills into index 0: result must not be written, read still happens (R8).
    issue(2'b00, 32'h0000_0021, 32'hDEADBEEF, 5'd0);
    issue(2'b01, 32'h0000_0023, 32'hCAFEF00D, 5'd0);

    // Spill then fill of the same word: read-modify-write visible (R5, R3).
    issue(2'b10, 32'h8000_0031, 32'h55667788, 5'd9);
    issue(2'b11, 32'h8000_0032, 32'h99AABBCC, 5'd9);
    issue(2'b00, 32'h8000_0030, 32'h0, 5'd10);
    issue(2'b01, 32'h8000_0030, 32'h0, 5'd11);

    // Mixed traffic with result back-pressure (R9).
    bp_mode = 1;
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(lf[1:0], {24'h0, 2'b0, lf[9:4]}, lf ^ 32'h5A5A_0F0F, lf[14:10]);
    end
    bp_mode = 0;

    while (res_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_rd == n_req, "R7 one read per request", n_rd, n_req);
    chk(n_wr == n_spill, "R7 one write per spill", n_wr, n_spill);
    chk(rda_q.size() == 0 && wr_q.size() == 0, "R2 all strobes seen",
        rda_q.size(), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule